// File: doc/BRIEF.md
# Multi-Mode Addressable Latch and Demultiplexer

This block holds eight single-bit latches behind a 3-bit address and one data input. Two active-low controls, a mode-wipe input and an enable, select one of four operating modes. In latch mode, the addressed bit takes the data value. In hold mode, nothing changes. In demultiplexer mode, only the addressed output is driven, and all the others are released. In clear mode, every output is released. The eight outputs model the level seen on active-low open-drain drivers, so a stored 1 shows as a 0 on its pin. A released output reads 1.

The block is fully synchronous. Every input is sampled on the rising clock edge, and every output comes from a register, so the effect of the inputs at edge k is visible just after edge k. Demultiplexer mode and clear mode both zero the stored bits. After either of those modes, a hold therefore shows all outputs high. Software or a sequencer that uses the block should keep the enable inactive while the address moves.

Top module: `addr_latch_demux`

## Requirements
- R1: With flush_n=1 and en_n=0 (latch mode), the stored bit at index addr takes din at the clock edge, and drv_n[addr] shows !din after that edge. Output bit i belongs to address i.
- R2: In latch mode, every output other than drv_n[addr] keeps its previous value, provided the previous cycle was not demultiplexer mode.
- R3: With flush_n=1 and en_n=1 (hold mode), all outputs keep their values and addr and din have no effect, provided the previous cycle was not demultiplexer mode.
- R4: With flush_n=0 and en_n=0 (demultiplexer mode), drv_n[addr] shows !din after the edge and every other output shows 1.
- R5: With flush_n=0 and en_n=1 (clear mode), all outputs show 1 after the edge, for any addr and din.
- R6: Demultiplexer mode and clear mode both zero all stored bits. A following hold shows 0xFF, and a following latch write shows only the newly written bit as low.
- R7: Inputs are sampled only on the rising clock edge. Outputs are registered and change only just after that edge.
- R8: A synchronous active-low reset (rst_n=0 at a clock edge) zeroes all stored bits and drives all outputs to 1. Data presented during reset is not stored.
- R9: Moving addr through all eight values while en_n=1 and flush_n=1 leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_n | input | 1 | Active-low mode-wipe control (low: demultiplexer or clear mode) |
| en_n | input | 1 | Active-low enable (low: latch or demultiplexer mode) |
| addr | input | 3 | Selects one of the eight bits |
| din | input | 1 | Data value for the addressed bit |
| drv_n | output | 8 | Registered, inverted output levels, bit i for address i |

## Verification
A fixed vector table steps the two controls through all sixteen ordered pairs of modes. Each step compares the full output byte, so it can tell a missed store-wipe after demultiplexer or clear mode apart from a missed override. Directed sweeps write every address with 1 and then with 0, which separates decode faults from inversion faults. An address sweep under hold, with changing data, exposes any write that leaks through the enable. A reset applied in the middle of a run, with data presented at the same time, shows whether the reset truly zeroes the stored bits.

// File: rtl/addr_latch_demux_pkg.sv
// Package: shared mode type and the decode from the two active-low controls.
// Assumes both controls are already synchronous to clk.
package addr_latch_demux_pkg;

    typedef enum logic [1:0] {
        MODE_LATCH = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } mode_t;

    // Map {flush_n, en_n} to an operating mode.
    function automatic mode_t decode_mode(input logic flush_n, input logic en_n);
        case ({flush_n, en_n})
            2'b10:   return MODE_LATCH;
            2'b11:   return MODE_HOLD;
            2'b00:   return MODE_DEMUX;
            default: return MODE_CLEAR;
        endcase
    endfunction

endpackage

// File: rtl/addr_latch_demux_mode.sv
// Module: turns the control pins into a mode and the address into a one-hot
// select vector. Purely combinational; assumes addr is below N_OUT.
module addr_latch_demux_mode
    import addr_latch_demux_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int N_OUT = 1 << ADDR_W
) (
    input  logic              flush_n,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] addr,
    output mode_t             mode,
    output logic [N_OUT-1:0]  sel
);

    // Mode decode from the two control pins.
    always_comb begin
        mode = decode_mode(flush_n, en_n);
    end

    // One-hot select, one entry per output.
    for (genvar i = 0; i < N_OUT; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i));
    end

endmodule

// File: rtl/addr_latch_demux_cell.sv
// Module: one stored bit together with its registered output level.
// It assumes that mode and sel are stable around the rising edge of clk.
// Reset is synchronous and active low. Both the stored bit and the output level are registered.
module addr_latch_demux_cell
    import addr_latch_demux_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode,
    input  logic  sel,
    input  logic  din,
    output logic  drv_n
);

    logic bit_q;
    logic bit_d;
    logic drv_d;

    // Next stored value: written when addressed in latch mode, wiped by demux/clear.
    always_comb begin
        case (mode)
            MODE_LATCH: bit_d = sel ? din : bit_q;
            MODE_HOLD:  bit_d = bit_q;
            default:    bit_d = 1'b0;
        endcase
    end

    // Next output level: inverted storage, or the demux override, or released.
    always_comb begin
        case (mode)
            MODE_LATCH: drv_d = ~bit_d;
            MODE_HOLD:  drv_d = ~bit_q;
            MODE_DEMUX: drv_d = sel ? ~din : 1'b1;
            default:    drv_d = 1'b1;
        endcase
    end

    // Storage and output registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
            drv_n <= 1'b1;
        end else begin
            bit_q <= bit_d;
            drv_n <= drv_d;
        end
    end

endmodule

// File: rtl/addr_latch_demux.sv
// Top: an addressable latch bank with four modes and inverted, registered outputs.
// It assumes all inputs are synchronous to clk. The caller keeps en_n high while addr changes.
module addr_latch_demux
    import addr_latch_demux_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int N_OUT = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_n,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic [N_OUT-1:0]  drv_n
);

    mode_t            mode;
    logic [N_OUT-1:0] sel;

    // Shared decode of mode and address.
    addr_latch_demux_mode #(.ADDR_W(ADDR_W)) u_mode (
        .flush_n (flush_n),
        .en_n    (en_n),
        .addr    (addr),
        .mode    (mode),
        .sel     (sel)
    );

    // One cell per output.
    for (genvar i = 0; i < N_OUT; i++) begin : g_cell
        addr_latch_demux_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .sel   (sel[i]),
            .din   (din),
            .drv_n (drv_n[i])
        );
    end

endmodule

// File: rtl/addr_latch_demux_checker.sv
// Checker: port-level properties of addr_latch_demux, attached by bind.
// It assumes the bench holds rst_n low from time zero.
module addr_latch_demux_checker #(
    parameter int ADDR_W = 3,
    localparam int N_OUT = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_n,
    input logic              en_n,
    input logic [ADDR_W-1:0] addr,
    input logic              din,
    input logic [N_OUT-1:0]  drv_n
);

    localparam logic [N_OUT-1:0] ONE = N_OUT'(1);

    logic is_latch, is_hold, is_demux, is_clear;
    assign is_latch = flush_n && !en_n;
    assign is_hold  = flush_n && en_n;
    assign is_demux = !flush_n && !en_n;
    assign is_clear = !flush_n && en_n;

    assert_latch_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        is_latch |=> drv_n[$past(addr)] == !$past(din));

    assert_latch_others_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_latch && !$past(is_demux)) |=>
            ((drv_n ^ $past(drv_n)) & ~(ONE << $past(addr))) == '0);

    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_hold && !$past(is_demux)) |=> $stable(drv_n));

    assert_demux_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_demux |=> (drv_n[$past(addr)] == !$past(din)) && ($countones(~drv_n) <= 1));

    assert_clear_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_clear |=> drv_n == '1);

    assert_wipe_then_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_hold && $past(is_demux)) |=> drv_n == '1);

    assert_reset_high_R8: assert property (@(posedge clk)
        !rst_n |=> drv_n == '1);

endmodule

bind addr_latch_demux addr_latch_demux_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_n (flush_n),
    .en_n    (en_n),
    .addr    (addr),
    .din     (din),
    .drv_n   (drv_n)
);

// File: tb/addr_latch_demux_test.sv
module addr_latch_demux_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush_n = 1'b1;
    logic       en_n = 1'b1;
    logic [2:0] addr = '0;
    logic       din = 1'b0;
    logic [7:0] drv_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    addr_latch_demux uut (
        .clk(clk), .rst_n(rst_n), .flush_n(flush_n), .en_n(en_n),
        .addr(addr), .din(din), .drv_n(drv_n)
    );

    // Vector layout: {flush_n, en_n, addr[2:0], din, expected[7:0], req[3:0]}
    localparam int NV = 26;
    localparam logic [17:0] VEC [NV] = '{
        {2'b10, 3'd0, 1'b1, 8'hFE, 4'd1}, // R1 latch
        {2'b10, 3'd1, 1'b1, 8'hFC, 4'd1}, // R1
        {2'b10, 3'd7, 1'b1, 8'h7C, 4'd2}, // R2
        {2'b10, 3'd0, 1'b0, 8'h7D, 4'd1}, // R1 write 0
        {2'b11, 3'd3, 1'b1, 8'h7D, 4'd3}, // R3 latch->hold
        {2'b11, 3'd5, 1'b0, 8'h7D, 4'd9}, // R9 hold->hold
        {2'b00, 3'd2, 1'b1, 8'hFB, 4'd4}, // R4 hold->demux
        {2'b11, 3'd2, 1'b0, 8'hFF, 4'd6}, // R6 demux->hold
        {2'b10, 3'd4, 1'b1, 8'hEF, 4'd6}, // R6 hold->latch
        {2'b00, 3'd4, 1'b0, 8'hFF, 4'd4}, // R4 latch->demux
        {2'b10, 3'd3, 1'b1, 8'hF7, 4'd6}, // R6 demux->latch
        {2'b01, 3'd3, 1'b1, 8'hFF, 4'd5}, // R5 latch->clear
        {2'b11, 3'd0, 1'b1, 8'hFF, 4'd6}, // R6 clear->hold
        {2'b10, 3'd6, 1'b1, 8'hBF, 4'd1}, // R1
        {2'b00, 3'd6, 1'b1, 8'hBF, 4'd4}, // R4
        {2'b10, 3'd5, 1'b1, 8'hDF, 4'd6}, // R6
        {2'b10, 3'd2, 1'b0, 8'hDF, 4'd2}, // R2
        {2'b11, 3'd1, 1'b1, 8'hDF, 4'd3}, // R3
        {2'b01, 3'd0, 1'b0, 8'hFF, 4'd5}, // R5 hold->clear
        {2'b00, 3'd1, 1'b1, 8'hFD, 4'd4}, // R4 clear->demux
        {2'b01, 3'd1, 1'b1, 8'hFF, 4'd5}, // R5 demux->clear
        {2'b10, 3'd3, 1'b1, 8'hF7, 4'd6}, // R6 clear->latch
        {2'b00, 3'd0, 1'b0, 8'hFF, 4'd4}, // R4 addressed output released
        {2'b00, 3'd7, 1'b1, 8'h7F, 4'd4}, // R4 demux->demux
        {2'b01, 3'd5, 1'b1, 8'hFF, 4'd5}, // R5
        {2'b01, 3'd2, 1'b0, 8'hFF, 4'd5}  // R5 clear->clear
    };

    function automatic string rtag(input int n);
        case (n)
            1: return "R1"; 2: return "R2"; 3: return "R3";
            4: return "R4"; 5: return "R5"; 6: return "R6";
            7: return "R7"; 8: return "R8"; default: return "R9";
        endcase
    endfunction

    task automatic check(input logic [7:0] exp, input string tag);
        total++;
        if (drv_n !== exp) begin
            bad++;
            $display("FAIL %s: drv_n=%h expected=%h", tag, drv_n, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then sample at the next falling edge.
    task automatic step(input logic f, input logic e, input logic [2:0] a, input logic d);
        flush_n = f; en_n = e; addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] model;
        logic [7:0] snap;
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        check(8'hFF, "R8 reset state");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][17], VEC[i][16], VEC[i][15:13], VEC[i][12]);
            check(VEC[i][11:4], rtag(int'(VEC[i][3:0])));
        end

        // R7: output changes only after the edge, not when inputs move mid-cycle.
        step(1'b0, 1'b1, 3'd0, 1'b0);
        flush_n = 1'b1; en_n = 1'b0; addr = 3'd2; din = 1'b1;
        #2;
        check(8'hFF, "R7 before edge");
        @(posedge clk);
        @(negedge clk);
        check(8'hFB, "R7 after edge");

        // R1: every address written with 1, then with 0.
        step(1'b0, 1'b1, 3'd0, 1'b0);
        model = '0;
        for (int a = 0; a < 8; a++) begin
            step(1'b1, 1'b0, 3'(a), 1'b1);
            model[a] = 1'b1;
            check(~model, "R1 write one");
        end
        for (int a = 0; a < 8; a++) begin
            step(1'b1, 1'b0, 3'(a), 1'b0);
            model[a] = 1'b0;
            check(~model, "R1 write zero");
        end

        // R9: address sweep under hold with changing data.
        step(1'b1, 1'b0, 3'd1, 1'b1);
        step(1'b1, 1'b0, 3'd4, 1'b1);
        snap = 8'hED;
        check(snap, "R2 pattern");
        for (int a = 0; a < 8; a++) begin
            step(1'b1, 1'b1, 3'(a), a[0]);
            check(snap, "R9 hold sweep");
        end

        // R8: reset in mid-run with a write presented.
        rst_n = 1'b0;
        step(1'b1, 1'b0, 3'd0, 1'b1);
        check(8'hFF, "R8 reset mid-run");
        rst_n = 1'b1;
        step(1'b1, 1'b1, 3'd0, 1'b1);
        check(8'hFF, "R8 storage zeroed");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: done=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule